// File: doc/BRIEF.md
# Trigger Release Waiter

This block sits between a level-type request trigger and a transfer engine. Each time the engine reports that it has finished the unit of work a trigger asks for, the block decides whether to hold off further triggers until the requesting agent lowers its request. Without this hold-off, a request line that is still high would be taken as a fresh request. The agent usually keeps the line high until it has consumed the data, and it may drop it a few cycles late.

A 2-bit wait mode selects the behaviour:

- `2'b00`: no wait, for pulse-type triggers.
- `2'b01`: a short bounded wait of `SHORT_LIMIT` cycles.
- `2'b10`: a long bounded wait of `LONG_LIMIT` cycles.
- `2'b11`: an unbounded wait. This mode locks the block if the trigger never drops.

The mode is captured when the completion strobe is accepted. The trigger input is assumed to be already synchronized. Only completion strobes from the engine start a wait, not individual bus beats.

The controller has two states:

- `ST_READY` (ready high).
- `ST_WAIT` (waiting high).

It has three transitions:

- `GO_WAIT`: `ST_READY` to `ST_WAIT`, on a completion strobe with a nonzero mode.
- `RELEASE`: `ST_WAIT` to `ST_READY`, when the trigger is seen low.
- `TIMEOUT`: `ST_WAIT` to `ST_READY`, in the last allowed cycle of a bounded mode.

A completion strobe with mode `2'b00` keeps the controller in `ST_READY`.

Top module: `trig_release_waiter`

## Requirements
- R1: After a synchronous active-high reset, `ready` is 1 and `waiting` is 0, including when reset is applied during a wait.
- R2: A completion strobe with mode `2'b00` leaves `ready` at 1, and `waiting` stays 0.
- R3: A completion strobe while ready, with a nonzero mode, makes `waiting` 1 and `ready` 0 from the next cycle.
- R4: In mode `2'b01` with the trigger held high, `waiting` stays high for exactly `SHORT_LIMIT` cycles (4 by default), then `ready` returns.
- R5: In mode `2'b10` with the trigger held high, `waiting` stays high for exactly `LONG_LIMIT` cycles (16 by default), then `ready` returns.
- R6: In mode `2'b11` the wait has no cycle limit; `waiting` stays high for as long as the trigger stays high.
- R7: When the trigger is seen low in a waiting cycle, `ready` returns on the next cycle. The wait therefore lasts the number of cycles until the trigger drops, and at least one cycle.
- R8: Completion strobes that arrive during a wait are ignored and do not restart or extend it.
- R9: The mode is captured with the accepted completion strobe; changing `wait_mode` during a wait does not change that wait's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_lvl | input | 1 | Synchronized request trigger level |
| unit_done | input | 1 | One-cycle strobe: the engine finished a trigger's unit of work |
| wait_mode | input | 2 | Wait policy: 00 none, 01 short, 10 long, 11 unbounded |
| ready | output | 1 | High when a new trigger may be accepted |
| waiting | output | 1 | High while holding off for trigger release |

## Verification
The bench builds the block with the default limits of 4 and 16. With these values, both bounded timeouts are reached in full and the cycle counts can be compared exactly, alongside early releases that end a wait before its limit. The unbounded mode is held for 40 cycles, well past the long limit, to show that no hidden bound exists. Further scenarios cover strobes arriving mid-wait, mode changes mid-wait, and reset during a wait.

// File: rtl/trw_pkg.sv
package trw_pkg;
    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_WAIT  = 1'b1
    } trw_state_e;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'b00,
        MODE_SHORT = 2'b01,
        MODE_LONG  = 2'b10,
        MODE_HOLD  = 2'b11
    } trw_mode_e;
endpackage

// File: rtl/trw_limit_sel.sv
// Maps a captured wait mode onto the last counter value of a bounded wait.
module trw_limit_sel #(
    parameter int SHORT_LIMIT = 4,
    parameter int LONG_LIMIT  = 16,
    parameter int CNT_W       = 5
) (
    input  logic [1:0]       mode,
    output logic [CNT_W-1:0] last_cnt,
    output logic             unbounded
);
    import trw_pkg::*;

    always_comb begin
        last_cnt  = '0;
        unbounded = 1'b0;
        unique case (trw_mode_e'(mode))
            MODE_SHORT: last_cnt  = CNT_W'(SHORT_LIMIT - 1);
            MODE_LONG:  last_cnt  = CNT_W'(LONG_LIMIT - 1);
            MODE_HOLD:  unbounded = 1'b1;
            MODE_NONE:  last_cnt  = '0;
        endcase
    end
endmodule

// File: rtl/trw_counter.sv
// Saturating cycle counter with synchronous clear.
module trw_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/trig_release_waiter.sv
// Post-completion hold-off until a level request trigger is released.
module trig_release_waiter #(
    parameter int SHORT_LIMIT = 4,
    parameter int LONG_LIMIT  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_lvl,
    input  logic       unit_done,
    input  logic [1:0] wait_mode,
    output logic       ready,
    output logic       waiting
);
    import trw_pkg::*;

    localparam int MAX_LIMIT = (LONG_LIMIT > SHORT_LIMIT) ? LONG_LIMIT : SHORT_LIMIT;
    localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

    trw_state_e       state_q, state_d;
    logic [1:0]       mode_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;
    logic             unbounded;
    logic             go_wait, release_seen, timeout_hit;

    trw_limit_sel #(
        .SHORT_LIMIT(SHORT_LIMIT),
        .LONG_LIMIT (LONG_LIMIT),
        .CNT_W      (CNT_W)
    ) u_limit (
        .mode     (mode_q),
        .last_cnt (last_cnt),
        .unbounded(unbounded)
    );

    trw_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (state_q == ST_READY),
        .inc  (state_q == ST_WAIT),
        .count(cnt)
    );

    // Transition conditions
    assign go_wait      = unit_done && (trw_mode_e'(wait_mode) != MODE_NONE);
    assign release_seen = !trig_lvl;
    assign timeout_hit  = !unbounded && (cnt == last_cnt);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (go_wait) state_d = ST_WAIT;
            ST_WAIT:  if (release_seen || timeout_hit) state_d = ST_READY;
        endcase
    end

    // State and captured mode
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READY;
            mode_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_READY) && unit_done) begin
                mode_q <= wait_mode;
            end
        end
    end

    // Outputs
    always_comb begin
        ready   = 1'b0;
        waiting = 1'b0;
        unique case (state_q)
            ST_READY: ready   = 1'b1;
            ST_WAIT:  waiting = 1'b1;
        endcase
    end
endmodule

// File: rtl/trw_checker.sv
module trw_checker #(
    parameter int SHORT_LIMIT = 4,
    parameter int LONG_LIMIT  = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       trig_lvl,
    input logic       unit_done,
    input logic [1:0] wait_mode,
    input logic       ready,
    input logic       waiting
);
    localparam int CW = $clog2(LONG_LIMIT + SHORT_LIMIT + 2) + 1;

    logic [CW-1:0] chk_cnt;
    logic [1:0]    chk_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_cnt  <= '0;
            chk_mode <= 2'b00;
        end else if (ready && unit_done) begin
            chk_cnt  <= '0;
            chk_mode <= wait_mode;
        end else if (waiting && (chk_cnt != '1)) begin
            chk_cnt <= chk_cnt + 1'b1;
        end
    end

    assert_mode0_stays_R2: assert property (@(posedge clk) disable iff (rst)
        ready && unit_done && (wait_mode == 2'b00) |=> ready && !waiting);

    assert_enter_wait_R3: assert property (@(posedge clk) disable iff (rst)
        ready && unit_done && (wait_mode != 2'b00) |=> waiting && !ready);

    assert_short_bound_R4: assert property (@(posedge clk) disable iff (rst)
        waiting && (chk_mode == 2'b01) |-> chk_cnt < CW'(SHORT_LIMIT));

    assert_short_hold_R4: assert property (@(posedge clk) disable iff (rst)
        waiting && trig_lvl && (chk_mode == 2'b01) && (chk_cnt < CW'(SHORT_LIMIT - 1)) |=> waiting);

    assert_long_bound_R5: assert property (@(posedge clk) disable iff (rst)
        waiting && (chk_mode == 2'b10) |-> chk_cnt < CW'(LONG_LIMIT));

    assert_long_hold_R5: assert property (@(posedge clk) disable iff (rst)
        waiting && trig_lvl && (chk_mode == 2'b10) && (chk_cnt < CW'(LONG_LIMIT - 1)) |=> waiting);

    assert_unbounded_hold_R6: assert property (@(posedge clk) disable iff (rst)
        waiting && trig_lvl && (chk_mode == 2'b11) |=> waiting);

    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        waiting && !trig_lvl |=> ready && !waiting);
endmodule

bind trig_release_waiter trw_checker #(
    .SHORT_LIMIT(SHORT_LIMIT),
    .LONG_LIMIT (LONG_LIMIT)
) u_trw_checker (
    .clk      (clk),
    .rst      (rst),
    .trig_lvl (trig_lvl),
    .unit_done(unit_done),
    .wait_mode(wait_mode),
    .ready    (ready),
    .waiting  (waiting)
);

// File: tb/test_trig_release_waiter.sv
`timescale 1ns/1ps
module test_trig_release_waiter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trig_lvl = 1'b0;
    logic       unit_done = 1'b0;
    logic [1:0] wait_mode = 2'b00;
    logic       ready, waiting;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    trig_release_waiter i_trig_release_waiter (
        .clk(clk), .rst(rst), .trig_lvl(trig_lvl), .unit_done(unit_done),
        .wait_mode(wait_mode), .ready(ready), .waiting(waiting)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts a wait and measures its length in cycles.
    // hold: waiting cycles after which trig drops (0 = low at completion).
    // done_at / mode_at: waiting cycle at which to pulse unit_done / change wait_mode (0 = never).
    task automatic run_wait(input logic [1:0] mode, input int hold, input int done_at,
                            input int mode_at, input int expected, input string req);
        int n;
        @(negedge clk);
        trig_lvl  = (hold > 0);
        wait_mode = mode;
        unit_done = 1'b1;
        @(negedge clk);
        unit_done = 1'b0;
        check(waiting == 1'b1 && ready == 1'b0, "R3 enter wait", waiting, 1);
        n = 0;
        while (waiting && n < 500) begin
            n++;
            unit_done = (n == done_at);
            if (n == mode_at) wait_mode = 2'b00;
            if (n == hold) trig_lvl = 1'b0;
            @(negedge clk);
        end
        unit_done = 1'b0;
        check(n == expected, req, n, expected);
        check(ready == 1'b1, {req, " ready back"}, ready, 1);
        trig_lvl = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(ready == 1'b1 && waiting == 1'b0, "R1 reset state", ready, 1);
        rst = 1'b0;
    endtask

    task automatic t_mode0;
        @(negedge clk);
        trig_lvl = 1'b1; wait_mode = 2'b00; unit_done = 1'b1;
        @(negedge clk);
        unit_done = 1'b0;
        check(ready == 1'b1 && waiting == 1'b0, "R2 mode0 no wait", waiting, 0);
        repeat (3) @(negedge clk);
        check(waiting == 1'b0, "R2 mode0 later", waiting, 0);
        trig_lvl = 1'b0;
    endtask

    task automatic t_short;
        run_wait(2'b01, 1000, 0, 0, 4, "R4 short timeout");
        run_wait(2'b01, 2, 0, 0, 2, "R7 short early release");
    endtask

    task automatic t_long;
        run_wait(2'b10, 1000, 0, 0, 16, "R5 long timeout");
        run_wait(2'b10, 10, 0, 0, 10, "R7 long early release");
        run_wait(2'b10, 0, 0, 0, 1, "R7 trigger already low");
    endtask

    task automatic t_unbounded;
        run_wait(2'b11, 40, 0, 0, 40, "R6 unbounded hold");
    endtask

    task automatic t_ignore_done;
        run_wait(2'b10, 1000, 5, 0, 16, "R8 strobe during wait");
        run_wait(2'b01, 1000, 3, 0, 4, "R8 strobe near short end");
    endtask

    task automatic t_mode_latched;
        run_wait(2'b01, 1000, 0, 1, 4, "R9 mode change mid wait");
        run_wait(2'b10, 1000, 0, 2, 16, "R9 long mode change");
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        trig_lvl = 1'b1; wait_mode = 2'b11; unit_done = 1'b1;
        @(negedge clk);
        unit_done = 1'b0;
        repeat (3) @(negedge clk);
        check(waiting == 1'b1, "R6 still waiting", waiting, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(ready == 1'b1 && waiting == 1'b0, "R1 reset mid wait", waiting, 0);
        trig_lvl = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_mode0();
        t_short();
        t_long();
        t_unbounded();
        t_ignore_done();
        t_mode_latched();
        t_reset_mid();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule